// File: doc/BRIEF.md
# Sv32 Address Translation Unit

This block turns 32-bit virtual addresses into 34-bit physical addresses for a core that runs in supervisor and machine mode. A small fully associative translation cache holds recent leaf entries. On a miss, a hardware walker fetches page table entries through a dedicated read port, so software never refills the cache. Both 4 KiB pages and 4 MiB megapages are handled, and both kinds are cached side by side.

A client offers one request at a time: a virtual address, an access kind and a privilege flag. It may offer the next one once `req_ready` is high again. Each accepted request produces a single-cycle `rsp_valid` pulse that carries either a physical address or a page fault together with the faulting address. The translation register input selects whether translation is on and where the root table sits. A one-cycle flush pulse empties the cache after the page tables change. The accessed and dirty bits are never written back: an entry that would need an update raises a fault instead.

Top module: `sv32_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: When `req_smode`=0 (machine mode) or `satp[31]`=0, the response is `rsp_paddr`={2'b00, vaddr} with no fault, and no table read is issued.
- R3: Page table entries use the layout V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, A=bit6, D=bit7, PPN=bits[31:10]. The first read goes to {satp[21:0], va[31:22], 2'b00}. An entry with V=1 and R=X=0 is a pointer, and the second read goes to {pte[31:10], va[21:12], 2'b00}. A second-level leaf gives `rsp_paddr`={pte[31:10], va[11:0]}.
- R4: A first-level leaf (R or X set) is a megapage. It needs only one read and gives `rsp_paddr`={pte[31:20], va[21:0]}.
- R5: A megapage leaf with pte[19:10] nonzero faults.
- R6: Each of the following faults: V=0 at either level, W=1 with R=0, a pointer found at the second level, or a leaf with A=0.
- R7: A load (`req_acc`=00) needs R. A store (01) needs both W and D. A fetch (10) needs X. Otherwise the access faults.
- R8: A supervisor-mode access to a page with U=1 faults for fetches always, and for loads and stores unless `sum`=1.
- R9: On a fault, `rsp_fault`=1, `rsp_tval` is the request's virtual address and `rsp_paddr` is 0. Without a fault, `rsp_tval` is 0.
- R10: Translating a page whose leaf is cached issues no table read and gives the same address. Permissions are checked again on every hit, so a store to a cached read-only page faults without a read.
- R11: The cache has 4 entries and refills them round-robin. After five different pages are walked in turn, the first one walks again and the other four hit.
- R12: After a `flush` pulse, every previously cached page is walked again.
- R13: `req_ready` is low from acceptance until the response. `rsp_valid` is a one-cycle pulse per accepted request. `mem_rd_req` holds with a stable `mem_rd_addr` until `mem_rd_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_smode | input | 1 | 1 = supervisor, 0 = machine (untranslated) |
| satp | input | 32 | Bit 31 translation on, bits 21:0 root table page number |
| sum | input | 1 | Lets supervisor loads and stores touch user pages |
| flush | input | 1 | One-cycle pulse that invalidates all cached entries |
| mem_rd_req | output | 1 | Table entry read pending |
| mem_rd_addr | output | 34 | Physical address of the entry |
| mem_rd_rvalid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 34 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_tval | output | 32 | Faulting virtual address |

## Verification
The hardest state to reach from the ports is a cache that is full, with a known victim next in line, because the replacement pointer is not visible and earlier tests have moved it. The stimulus first flushes the cache and then walks four fresh pages, which fill all four slots whatever the pointer was. A fifth page must then evict the first of the four. Cache hits and misses are told apart only by counting the reads the bench memory serves, so every check of cached behaviour compares that count as well as the address.

// File: rtl/sv32_pkg.sv
`timescale 1ns/1ps
// Shared widths and the cached leaf record for the Sv32 translation unit.
package sv32_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 34;
    localparam int PPN_W = 22;
    localparam int VPN_W = 20;
    localparam int OFF_W = 12;

    // Leaf permissions and frame number as kept in the cache.
    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic d;
        logic a;
        logic u;
        logic x;
        logic w;
        logic r;
        logic mega;
    } leaf_t;
endpackage

// File: rtl/sv32_perm.sv
`timescale 1ns/1ps
// Permission judge for one leaf: decides whether the access kind and the
// supervisor user-page rule allow the access. Assumes supervisor privilege,
// since machine-mode requests never reach it.
module sv32_perm
    import sv32_pkg::*;
(
    input  leaf_t      leaf,
    input  logic [1:0] acc,
    input  logic       sum,
    output logic       deny
);
    logic is_store, is_fetch, granted, user_block;

    // Decode the access kind and the rights it needs.
    always_comb begin
        is_store   = (acc == 2'b01);
        is_fetch   = (acc == 2'b10);
        granted    = is_fetch ? leaf.x : (is_store ? (leaf.w & leaf.d) : leaf.r);
        user_block = leaf.u & (is_fetch | ~sum);
        deny       = ~granted | user_block;
    end
endmodule

// File: rtl/sv32_tlb.sv
`timescale 1ns/1ps
// Fully associative leaf cache with round-robin refill. A megapage entry
// matches on the upper ten page bits only. A flush clears every valid bit in
// one cycle and wins over a refill in the same cycle.
module sv32_tlb
    import sv32_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output leaf_t            hit_leaf,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  leaf_t            fill_leaf
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int HI_W  = VPN_W / 2;

    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   tag  [ENTRIES];
    leaf_t              data [ENTRIES];
    logic [IDX_W-1:0]   ptr;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] &&
            (data[g].mega ? (tag[g][VPN_W-1:VPN_W-HI_W] == look_vpn[VPN_W-1:VPN_W-HI_W])
                          : (tag[g] == look_vpn));
    end

    // Select the lowest-numbered matching entry.
    always_comb begin
        hit      = 1'b0;
        hit_leaf = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_leaf = data[i];
            end
        end
    end

    // Valid bits and the replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Tag and leaf storage written at the pointed slot.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag[ptr]  <= fill_vpn;
            data[ptr] <= fill_leaf;
        end
    end
endmodule

// File: rtl/sv32_walker.sv
`timescale 1ns/1ps
// Two-level table walker. Holds the read request until the memory answers,
// follows one pointer at most, and judges the structure of the leaf found.
// The result (done, fault, leaf) is valid only in the cycle the data returns.
module sv32_walker
    import sv32_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [VPN_W-1:0] vpn,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_rvalid,
    input  logic [31:0]      mem_rd_data,
    output logic             done,
    output logic             fault,
    output leaf_t            leaf
);
    localparam int HALF = VPN_W / 2;

    typedef enum logic [1:0] {W_IDLE, W_L1, W_L2} wst_e;

    wst_e            st;
    logic [PA_W-1:0] addr_q;
    logic [HALF-1:0] vpn0_q;
    logic pv, pr, pw, px, pa, is_leaf, bad, unused_bits;

    assign unused_bits = ^{mem_rd_data[9:8], mem_rd_data[5]};
    assign mem_rd_req  = (st != W_IDLE);
    assign mem_rd_addr = addr_q;
    assign leaf = {mem_rd_data[31:10], mem_rd_data[7], mem_rd_data[6], mem_rd_data[4],
                   mem_rd_data[3], mem_rd_data[2], mem_rd_data[1], (st == W_L1)};

    // Judge the returned entry.
    always_comb begin
        pv      = mem_rd_data[0];
        pr      = mem_rd_data[1];
        pw      = mem_rd_data[2];
        px      = mem_rd_data[3];
        pa      = mem_rd_data[6];
        is_leaf = pr | px;
        bad     = ~pv | (pw & ~pr) | (is_leaf & ~pa) |
                  ((st == W_L1) & is_leaf & (mem_rd_data[19:10] != '0)) |
                  ((st == W_L2) & ~is_leaf);
        fault   = bad;
        done    = (st != W_IDLE) & mem_rd_rvalid & (bad | is_leaf);
    end

    // Walk sequencing and read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= W_IDLE;
            addr_q <= '0;
            vpn0_q <= '0;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    addr_q <= {root_ppn, vpn[VPN_W-1:HALF], 2'b00};
                    vpn0_q <= vpn[HALF-1:0];
                    st     <= W_L1;
                end
                W_L1: if (mem_rd_rvalid) begin
                    if (done) st <= W_IDLE;
                    else begin
                        addr_q <= {mem_rd_data[31:10], vpn0_q, 2'b00};
                        st     <= W_L2;
                    end
                end
                W_L2: if (mem_rd_rvalid) st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sv32_xlate.sv
`timescale 1ns/1ps
// Sv32 translation unit: accepts one request at a time, bypasses machine
// mode and disabled translation, looks up the leaf cache, walks on a miss,
// refills the cache with structurally sound leaves and returns one
// registered response pulse. Assumes satp and sum stay steady while busy.
module sv32_xlate
    import sv32_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_smode,
    input  logic [31:0]       satp,
    input  logic              sum,
    input  logic              flush,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_rvalid,
    input  logic [31:0]       mem_rd_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_tval
);
    typedef enum logic [1:0] {T_IDLE, T_LOOK, T_WALK} tst_e;

    tst_e            st;
    logic [VA_W-1:0] va_q;
    logic [1:0]      acc_q;
    logic            smode_q;
    logic            bypass, hit, deny, walk_start, walk_done, walk_fault, fill;
    logic            fin, fin_fault, unused_satp;
    logic [PA_W-1:0] fin_pa;
    leaf_t           hit_leaf, walk_leaf, chk_leaf;

    function automatic logic [PA_W-1:0] compose(leaf_t l, logic [VA_W-1:0] va);
        return l.mega ? {l.ppn[PPN_W-1:10], va[21:0]} : {l.ppn, va[OFF_W-1:0]};
    endfunction

    assign unused_satp = ^satp[30:PPN_W];
    assign req_ready   = (st == T_IDLE);
    assign bypass      = ~smode_q | ~satp[31];
    assign chk_leaf    = (st == T_WALK) ? walk_leaf : hit_leaf;

    sv32_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .look_vpn(va_q[VA_W-1:OFF_W]), .hit(hit), .hit_leaf(hit_leaf),
        .fill_en(fill), .fill_vpn(va_q[VA_W-1:OFF_W]), .fill_leaf(walk_leaf)
    );

    sv32_walker u_walk (
        .clk(clk), .rst_n(rst_n), .start(walk_start),
        .root_ppn(satp[PPN_W-1:0]), .vpn(va_q[VA_W-1:OFF_W]),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
        .done(walk_done), .fault(walk_fault), .leaf(walk_leaf)
    );

    sv32_perm u_perm (.leaf(chk_leaf), .acc(acc_q), .sum(sum), .deny(deny));

    // Decide the outcome of the current cycle.
    always_comb begin
        fin        = 1'b0;
        fin_fault  = 1'b0;
        fin_pa     = '0;
        walk_start = 1'b0;
        fill       = 1'b0;
        case (st)
            T_LOOK: begin
                if (bypass) begin
                    fin    = 1'b1;
                    fin_pa = {2'b00, va_q};
                end else if (hit) begin
                    fin       = 1'b1;
                    fin_fault = deny;
                    fin_pa    = compose(hit_leaf, va_q);
                end else begin
                    walk_start = 1'b1;
                end
            end
            T_WALK: if (walk_done) begin
                fin       = 1'b1;
                fin_fault = walk_fault | deny;
                fin_pa    = compose(walk_leaf, va_q);
                fill      = ~walk_fault;
            end
            default: ;
        endcase
    end

    // Request capture, control state and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= T_IDLE;
            va_q      <= '0;
            acc_q     <= '0;
            smode_q   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_tval  <= '0;
        end else begin
            rsp_valid <= fin;
            if (fin) begin
                rsp_paddr <= fin_fault ? '0 : fin_pa;
                rsp_fault <= fin_fault;
                rsp_tval  <= fin_fault ? va_q : '0;
            end
            case (st)
                T_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    acc_q   <= req_acc;
                    smode_q <= req_smode;
                    st      <= T_LOOK;
                end
                T_LOOK:  st <= fin ? T_IDLE : T_WALK;
                T_WALK:  if (fin) st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sv32_xlate_chk.sv
`timescale 1ns/1ps
// Port-level checker for sv32_xlate: tracks the accepted request on its own
// and relates responses and table reads to it.
module sv32_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_smode,
    input logic [31:0] satp,
    input logic        mem_rd_req,
    input logic [33:0] mem_rd_addr,
    input logic        mem_rd_rvalid,
    input logic        rsp_valid,
    input logic [33:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [31:0] rsp_tval
);
    logic [31:0] c_va;
    logic        c_trans, c_pend, unused_satp;

    assign unused_satp = ^satp[30:0];

    // Record the accepted request and whether a response is owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_va    <= '0;
            c_trans <= 1'b0;
            c_pend  <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                c_va    <= req_vaddr;
                c_trans <= req_smode & satp[31];
                c_pend  <= 1'b1;
            end else if (rsp_valid) begin
                c_pend  <= 1'b0;
            end
        end
    end

    p_bypass_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !c_trans |-> rsp_paddr == {2'b00, c_va} && !rsp_fault);
    p_bypass_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> c_trans && c_pend);
    p_offset_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == c_va[11:0]);
    p_mem_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[1:0] == 2'b00);
    p_fault_tval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_tval == c_va && rsp_paddr == '0);
    p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_owed_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> c_pend);
    p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        c_pend && !rsp_valid |-> !req_ready);
    p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_rvalid |=> mem_rd_req && $stable(mem_rd_addr));
endmodule

bind sv32_xlate sv32_xlate_chk u_chk (.*);

// File: tb/sim_sv32_xlate.sv
`timescale 1ns/1ps
// Directed bench: a memory model serving table reads after a short delay,
// one task per scenario, results compared against values from the brief.
module sim_sv32_xlate;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_smode = 1'b1, sum = 1'b0, flush = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = 2'b00;
    logic [31:0] satp;
    logic        req_ready, mem_rd_req, mem_rd_rvalid, rsp_valid, rsp_fault;
    logic [33:0] mem_rd_addr, rsp_paddr;
    logic [31:0] mem_rd_data, rsp_tval;

    localparam logic [21:0] ROOT = 22'h10;
    localparam logic [21:0] L2T  = 22'h11;
    localparam logic [21:0] FRM  = 22'h20000;
    localparam logic [31:0] SATP_ON = {1'b1, 9'b0, ROOT};
    localparam logic [1:0]  LD = 2'b00, ST = 2'b01, FE = 2'b10;

    int          n_cmp = 0, n_bad = 0, rd_count = 0, lat = 0;
    logic [33:0] rd_log [8];
    logic [31:0] pmem [2048];
    logic        done_flag = 1'b0;

    always #2.5 clk = ~clk;

    sv32_xlate #(.TLB_ENTRIES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_smode(req_smode),
        .satp(satp), .sum(sum), .flush(flush),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_tval(rsp_tval)
    );

    function automatic int midx(logic [33:0] a);
        return int'({a[12], a[11:2]});
    endfunction

    // Memory model: answers a held read two cycles later.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_rvalid <= 1'b0;
            mem_rd_data   <= '0;
            lat           <= 0;
        end else begin
            mem_rd_rvalid <= 1'b0;
            if (mem_rd_req && !mem_rd_rvalid) begin
                if (lat == 2) begin
                    mem_rd_rvalid     <= 1'b1;
                    mem_rd_data       <= pmem[midx(mem_rd_addr)];
                    rd_log[rd_count % 8] <= mem_rd_addr;
                    rd_count          <= rd_count + 1;
                    lat               <= 0;
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xl(input logic [31:0] va, input logic [1:0] acc, input logic sm,
                      input logic sumv, output logic [33:0] pa, output logic flt,
                      output logic [31:0] tv, output int reads, output logic busy);
        int r0;
        int t;
        t = 0;
        @(negedge clk);
        r0 = rd_count;
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_smode = sm; sum = sumv;
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        while (!rsp_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        if (t >= 200) chk("R13 response timeout", 1, 0);
        pa = rsp_paddr; flt = rsp_fault; tv = rsp_tval; reads = rd_count - r0;
        @(negedge clk);
        chk("R13 single pulse", rsp_valid, 0);
    endtask

    function automatic logic [31:0] va4k(int k, logic [11:0] off);
        return 32'h0040_0000 | (32'(k) << 12) | {20'b0, off};
    endfunction

    function automatic logic [33:0] pa4k(int k, logic [11:0] off);
        return {FRM + 22'(k), off};
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no response after reset", rsp_valid, 0);
        chk("R1 no read after reset", mem_rd_req, 0);
    endtask

    task automatic t_bypass();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(32'hDEAD_BEEF, ST, 1'b0, 1'b0, pa, f, tv, n, b);
        chk("R2 machine mode address", {f, pa}, {1'b0, 2'b00, 32'hDEAD_BEEF});
        chk("R2 machine mode reads", n, 0);
        xl(32'h0100_0000, LD, 1'b0, 1'b0, pa, f, tv, n, b);
        chk("R2 machine mode ignores bad table", {f, pa}, {1'b0, 34'h0100_0000});
        @(negedge clk); satp = 32'h0000_0010;
        xl(32'h0040_0123, FE, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R2 translation off address", {f, pa}, {1'b0, 34'h0040_0123});
        chk("R2 translation off reads", n, 0);
        @(negedge clk); satp = SATP_ON;
    endtask

    task automatic t_walk4k();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(va4k(0, 12'hABC), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R3 4K address", {f, pa}, {1'b0, pa4k(0, 12'hABC)});
        chk("R3 4K reads", n, 2);
        chk("R3 first read address", rd_log[(rd_count - 2) % 8], {ROOT, 10'd1, 2'b00});
        chk("R3 second read address", rd_log[(rd_count - 1) % 8], {L2T, 10'd0, 2'b00});
        chk("R9 no fault tval zero", tv, 0);
        chk("R13 busy after accept", b, 1);
    endtask

    task automatic t_mega();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(32'h008A_BCDE, LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R4 megapage address", {f, pa}, {1'b0, 12'h123, 22'h0A_BCDE});
        chk("R4 megapage one read", n, 1);
        chk("R4 megapage read address", rd_log[(rd_count - 1) % 8], {ROOT, 10'd2, 2'b00});
        xl(32'h00BF_F004, FE, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R10 megapage hit address", {f, pa}, {1'b0, 12'h123, 22'h3F_F004});
        chk("R10 megapage hit reads", n, 0);
    endtask

    task automatic t_misaligned();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(32'h00C0_0010, LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R5 misaligned megapage fault", f, 1);
        chk("R9 fault tval", tv, 32'h00C0_0010);
        chk("R9 fault paddr zero", pa, 0);
    endtask

    task automatic t_invalid();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(32'h0100_0000, LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R6 first level V=0", {f, 6'(n)}, {1'b1, 6'd1});
        for (int k = 4; k <= 7; k++) begin
            xl(va4k(k, 12'h010), LD, 1'b1, 1'b0, pa, f, tv, n, b);
            chk($sformatf("R6 second level bad entry %0d", k), {f, tv}, {1'b1, va4k(k, 12'h010)});
        end
    endtask

    task automatic t_perm();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(va4k(2, 12'h100), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 load on execute-only", f, 1);
        xl(va4k(2, 12'h104), FE, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 fetch on execute-only", {f, pa}, {1'b0, pa4k(2, 12'h104)});
        xl(va4k(0, 12'h008), FE, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 fetch without X", f, 1);
        xl(va4k(0, 12'h00C), ST, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 store with W and D", {f, pa}, {1'b0, pa4k(0, 12'h00C)});
        xl(va4k(12, 12'h020), ST, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 store with D=0", f, 1);
        xl(va4k(12, 12'h024), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R7 load with D=0", {f, pa}, {1'b0, pa4k(12, 12'h024)});
    endtask

    task automatic t_user();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(va4k(3, 12'h040), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R8 user page load sum=0", f, 1);
        xl(va4k(3, 12'h044), LD, 1'b1, 1'b1, pa, f, tv, n, b);
        chk("R8 user page load sum=1", {f, pa}, {1'b0, pa4k(3, 12'h044)});
        xl(va4k(3, 12'h048), ST, 1'b1, 1'b1, pa, f, tv, n, b);
        chk("R8 user page store sum=1", {f, pa}, {1'b0, pa4k(3, 12'h048)});
        xl(va4k(3, 12'h04C), FE, 1'b1, 1'b1, pa, f, tv, n, b);
        chk("R8 user page fetch sum=1", f, 1);
    endtask

    task automatic t_hit_perm();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(va4k(1, 12'h200), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R10 read-only load walk", {f, pa}, {1'b0, pa4k(1, 12'h200)});
        xl(va4k(1, 12'h204), ST, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R10 store to cached read-only faults", {f, 6'(n)}, {1'b1, 6'd0});
    endtask

    task automatic t_round_robin();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        int order [5] = '{8, 9, 10, 11, 0};
        do_flush();
        foreach (order[i]) begin
            xl(va4k(order[i], 12'h300), LD, 1'b1, 1'b0, pa, f, tv, n, b);
            chk($sformatf("R11 fill page %0d reads", order[i]), n, 2);
        end
        for (int k = 1; k < 5; k++) begin
            xl(va4k(order[k], 12'h304), LD, 1'b1, 1'b0, pa, f, tv, n, b);
            chk($sformatf("R11 kept page %0d", order[k]), {f, pa, 6'(n)},
                {1'b0, pa4k(order[k], 12'h304), 6'd0});
        end
        xl(va4k(8, 12'h308), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R11 evicted page walks again", n, 2);
    endtask

    task automatic t_flush();
        logic [33:0] pa; logic f, b; logic [31:0] tv; int n;
        xl(va4k(0, 12'h400), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R12 cached before flush", n, 0);
        do_flush();
        xl(va4k(0, 12'h404), LD, 1'b1, 1'b0, pa, f, tv, n, b);
        chk("R12 walk after flush", {f, pa, 6'(n)}, {1'b0, pa4k(0, 12'h404), 6'd2});
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Table contents: root at ROOT, second level at L2T.
    initial begin
        satp = SATP_ON;
        for (int i = 0; i < 2048; i++) pmem[i] = '0;
        pmem[1] = {L2T, 10'h001};
        pmem[2] = {12'h123, 10'h000, 10'h0CF};
        pmem[3] = {12'h124, 10'h005, 10'h0CF};
        pmem[1024 + 0]  = {FRM + 22'd0, 10'h0C7};
        pmem[1024 + 1]  = {FRM + 22'd1, 10'h043};
        pmem[1024 + 2]  = {FRM + 22'd2, 10'h049};
        pmem[1024 + 3]  = {FRM + 22'd3, 10'h0D7};
        pmem[1024 + 5]  = {FRM + 22'd5, 10'h0C5};
        pmem[1024 + 6]  = {FRM + 22'd6, 10'h087};
        pmem[1024 + 7]  = {FRM + 22'd7, 10'h001};
        for (int k = 8; k <= 11; k++) pmem[1024 + k] = {FRM + 22'(k), 10'h0C7};
        pmem[1024 + 12] = {FRM + 22'd12, 10'h047};
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_walk4k();
        t_mega();
        t_misaligned();
        t_invalid();
        t_perm();
        t_user();
        t_hit_perm();
        t_round_robin();
        t_flush();
        summary();
    end

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end
endmodule